// File: doc/BRIEF.md
# Endpoint Uncorrectable and Correctable Error Reporter

This block sits beside the receive and completion logic of a PCIe endpoint. Whenever that logic detects an error, it presents a one-cycle event that carries the error's bit index, a class flag (correctable or uncorrectable) and, for uncorrectable errors, the 128-bit header of the offending TLP. On the clock edge that takes the event, the block sets the matching bits in the advanced error status words, in the device status word and in the legacy status word. It also records the first uncorrectable error and its header. It then decides whether to request one error message toward the link: correctable, non-fatal or fatal.

That decision draws on several inputs: the per-error mask and severity words, the device-control reporting enables, the legacy command SERR enable, and a separate gate for unsupported requests. A flat word-addressed register port lets software program masks, severities and enables, read the logs, and clear status bits by writing 1. Events and message requests have no handshake. An event is taken on every cycle in which `ev_valid` is high. The consumer of `msg_valid` must accept a request in the cycle it appears, because the block never holds a request back.

Top module: `aer_err_report`

## Requirements
- R1: A correctable event with index n sets bit n of the correctable status word (address 4) and bit 0 of the device status word (address 12).
- R2: A correctable event whose bit in the correctable mask (address 5) is clear raises a message with code 0 only if device control (address 11) bit 0 is set. A masked correctable event raises no message.
- R3: An uncorrectable event with index n always sets bit n of the uncorrectable status word (address 1). It also sets device status bit 2 when bit n of the severity word (address 3) is 1 (fatal), and device status bit 1 otherwise.
- R4: Index 20 is the unsupported request. Index 15 is the completer abort. An uncorrectable unsupported request sets device status bit 3, and a completer abort sets legacy status (address 14) bit 11, whether or not the error is masked.
- R5: An uncorrectable event whose bit in the uncorrectable mask (address 2) is set raises no message. It also changes neither the first-error pointer, nor the header log, nor legacy status bit 14.
- R6: For an unmasked uncorrectable event, when the uncorrectable status word was zero before the event, bits 4:0 of the control word (address 6) take n. Header log words at addresses 7 to 10 then take header bits 31:0, 63:32, 95:64 and 127:96. Otherwise the pointer and the log keep their values.
- R7: An unmasked unsupported request raises no message when device control bit 3 is clear. When bit 3 is set, it raises code 2 if the error is fatal and code 1 if not. It never sets legacy status bit 14.
- R8: Any other unmasked uncorrectable event sets legacy status bit 14. It raises code 2 (fatal) or code 1 (non-fatal) when command word (address 13) bit 8 is set, or when device control bit 2 (fatal) or bit 1 (non-fatal) is set.
- R9: `msg_valid` is high for exactly the one cycle after the event's clock edge, with `msg_code` valid in that cycle. Each event raises at most one message.
- R10: After reset, address 0 reads {next pointer[11:0], 4'h1, 16'h0001} with the next pointer equal to its parameter value. Bits 31:20 of address 0 are writable. Address 6 reads 0x1E0, and its bits 8:5 are writable.
- R11: Status words (addresses 1, 4, 12, 14) clear the bits written with 1. A hardware set in the same cycle wins over the clear. The pointer bits and the header log ignore writes.
- R12: Decisions use mask, severity and enable values from before the event's edge, so a software write in the same cycle affects only later events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Error event strobe, one event per cycle |
| ev_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| ev_id | input | 5 | Error bit index in the status words |
| ev_hdr | input | 128 | Header of the failing TLP |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| msg_valid | output | 1 | One-cycle error message request |
| msg_code | output | 2 | 0 correctable, 1 non-fatal, 2 fatal |

## Verification
A software write-1-to-clear of a status word can land in the same cycle in which an event sets a bit of that word. The bench provokes this by holding an event and a clearing write on one clock edge. It then checks that the bit being set survives while another bit in the same write is cleared. A mask write in the same cycle as an event to the same bit is also driven, and the bench checks that the message follows the old mask and that a repeat of the event follows the new one.

// File: rtl/aer_pkg.sv
package aer_pkg;
  typedef enum logic [1:0] {
    MSG_COR      = 2'd0,
    MSG_NONFATAL = 2'd1,
    MSG_FATAL    = 2'd2
  } msg_code_e;

  localparam int ADDR_W = 4;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] A_CAPHDR  = 4'd0;
  localparam logic [ADDR_W-1:0] A_UNC_STS = 4'd1;
  localparam logic [ADDR_W-1:0] A_UNC_MSK = 4'd2;
  localparam logic [ADDR_W-1:0] A_UNC_SEV = 4'd3;
  localparam logic [ADDR_W-1:0] A_COR_STS = 4'd4;
  localparam logic [ADDR_W-1:0] A_COR_MSK = 4'd5;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd6;
  localparam logic [ADDR_W-1:0] A_LOG0    = 4'd7;
  localparam logic [ADDR_W-1:0] A_DEV_EN  = 4'd11;
  localparam logic [ADDR_W-1:0] A_DEV_STS = 4'd12;
  localparam logic [ADDR_W-1:0] A_CMD     = 4'd13;
  localparam logic [ADDR_W-1:0] A_LEG_STS = 4'd14;

  // device control / status bit positions
  localparam int DV_COR = 0;
  localparam int DV_NF  = 1;
  localparam int DV_FAT = 2;
  localparam int DV_UR  = 3;

  localparam int CMD_SERR = 8;
  localparam int LS_STA   = 11;
  localparam int LS_SSE   = 14;
endpackage

// File: rtl/aer_err_eval.sv
module aer_err_eval
  import aer_pkg::*;
#(
  parameter int STS_W  = 32,
  parameter int ID_W   = 5,
  parameter int UR_BIT = 20,
  parameter int CA_BIT = 15
) (
  input  logic             ev_valid,
  input  logic             ev_uncorr,
  input  logic [ID_W-1:0]  ev_id,
  input  logic [STS_W-1:0] unc_sts,
  input  logic [STS_W-1:0] unc_mask,
  input  logic [STS_W-1:0] unc_sev,
  input  logic [STS_W-1:0] cor_mask,
  input  logic [3:0]       dev_en,
  input  logic             serr_en,
  output logic [STS_W-1:0] unc_set,
  output logic [STS_W-1:0] cor_set,
  output logic [3:0]       dev_set,
  output logic             sta_set,
  output logic             sse_set,
  output logic             capture,
  output logic             fire,
  output msg_code_e        code
);
  logic [STS_W-1:0] sel;
  logic is_ur, is_ca, masked_u, masked_c, fatal, sev_en;

  assign sel      = {{(STS_W-1){1'b0}}, 1'b1} << ev_id;
  assign is_ur    = (ev_id == ID_W'(UR_BIT));
  assign is_ca    = (ev_id == ID_W'(CA_BIT));
  assign masked_u = |(unc_mask & sel);
  assign masked_c = |(cor_mask & sel);
  assign fatal    = |(unc_sev & sel);
  assign sev_en   = fatal ? dev_en[DV_FAT] : dev_en[DV_NF];

  always_comb begin
    unc_set = '0;
    cor_set = '0;
    dev_set = '0;
    sta_set = 1'b0;
    sse_set = 1'b0;
    capture = 1'b0;
    fire    = 1'b0;
    code    = MSG_COR;
    if (ev_valid && !ev_uncorr) begin
      cor_set         = sel;
      dev_set[DV_COR] = 1'b1;
      fire            = !masked_c && dev_en[DV_COR];
      code            = MSG_COR;
    end else if (ev_valid) begin
      unc_set = sel;
      if (fatal) dev_set[DV_FAT] = 1'b1;
      else       dev_set[DV_NF]  = 1'b1;
      dev_set[DV_UR] = is_ur;
      sta_set        = is_ca;
      code           = fatal ? MSG_FATAL : MSG_NONFATAL;
      if (!masked_u) begin
        capture = (unc_sts == '0);
        if (is_ur) begin
          fire = dev_en[DV_UR];
        end else begin
          sse_set = 1'b1;
          fire    = serr_en || sev_en;
        end
      end
    end
  end
endmodule

// File: rtl/aer_reg_bank.sv
module aer_reg_bank
  import aer_pkg::*;
#(
  parameter int             STS_W    = 32,
  parameter int             ID_W     = 5,
  parameter int             HDR_DW   = 4,
  parameter logic [11:0]    NEXT_RST = 12'h000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [WORD_W-1:0]       cfg_wdata,
  output logic [WORD_W-1:0]       cfg_rdata,
  input  logic [ID_W-1:0]         ev_id,
  input  logic [HDR_DW*WORD_W-1:0] ev_hdr,
  input  logic [STS_W-1:0]        unc_set,
  input  logic [STS_W-1:0]        cor_set,
  input  logic [3:0]              dev_set,
  input  logic                    sta_set,
  input  logic                    sse_set,
  input  logic                    capture,
  output logic [STS_W-1:0]        unc_sts,
  output logic [STS_W-1:0]        unc_mask,
  output logic [STS_W-1:0]        unc_sev,
  output logic [STS_W-1:0]        cor_sts,
  output logic [STS_W-1:0]        cor_mask,
  output logic [3:0]              dev_en,
  output logic                    serr_en
);
  localparam int CTL_PAD = WORD_W - ID_W - 4;

  logic [11:0]       next_ptr;
  logic [3:0]        ctl_rw;
  logic [ID_W-1:0]   fep;
  logic [3:0]        dev_sts;
  logic              leg_sta, leg_sse;
  logic [WORD_W-1:0] hdr_log [HDR_DW];

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return cfg_we && (cfg_addr == a);
  endfunction

  function automatic logic [WORD_W-1:0] clr(input logic [ADDR_W-1:0] a);
    return hit(a) ? cfg_wdata : '0;
  endfunction

  logic [WORD_W-1:0] leg_clr, dev_clr;
  assign leg_clr = clr(A_LEG_STS);
  assign dev_clr = clr(A_DEV_STS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_ptr <= NEXT_RST;
      ctl_rw   <= 4'hF;
      fep      <= '0;
      unc_sts  <= '0;
      unc_mask <= '0;
      unc_sev  <= '0;
      cor_sts  <= '0;
      cor_mask <= '0;
      dev_en   <= '0;
      dev_sts  <= '0;
      serr_en  <= 1'b0;
      leg_sta  <= 1'b0;
      leg_sse  <= 1'b0;
    end else begin
      if (hit(A_CAPHDR))  next_ptr <= cfg_wdata[31:20];
      if (hit(A_CTRL))    ctl_rw   <= cfg_wdata[ID_W+3:ID_W];
      if (hit(A_UNC_MSK)) unc_mask <= cfg_wdata[STS_W-1:0];
      if (hit(A_UNC_SEV)) unc_sev  <= cfg_wdata[STS_W-1:0];
      if (hit(A_COR_MSK)) cor_mask <= cfg_wdata[STS_W-1:0];
      if (hit(A_DEV_EN))  dev_en   <= cfg_wdata[3:0];
      if (hit(A_CMD))     serr_en  <= cfg_wdata[CMD_SERR];
      if (capture)        fep      <= ev_id;
      unc_sts <= (unc_sts & ~clr(A_UNC_STS)) | unc_set;
      cor_sts <= (cor_sts & ~clr(A_COR_STS)) | cor_set;
      dev_sts <= (dev_sts & ~dev_clr[3:0]) | dev_set;
      leg_sta <= (leg_sta & ~leg_clr[LS_STA]) | sta_set;
      leg_sse <= (leg_sse & ~leg_clr[LS_SSE]) | sse_set;
    end
  end

  for (genvar i = 0; i < HDR_DW; i++) begin : g_log
    always_ff @(posedge clk) begin
      if (!rst_n)       hdr_log[i] <= '0;
      else if (capture) hdr_log[i] <= ev_hdr[i*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_CAPHDR:  cfg_rdata = {next_ptr, 4'h1, 16'h0001};
      A_UNC_STS: cfg_rdata = WORD_W'(unc_sts);
      A_UNC_MSK: cfg_rdata = WORD_W'(unc_mask);
      A_UNC_SEV: cfg_rdata = WORD_W'(unc_sev);
      A_COR_STS: cfg_rdata = WORD_W'(cor_sts);
      A_COR_MSK: cfg_rdata = WORD_W'(cor_mask);
      A_CTRL:    cfg_rdata = {{CTL_PAD{1'b0}}, ctl_rw, fep};
      A_DEV_EN:  cfg_rdata = WORD_W'(dev_en);
      A_DEV_STS: cfg_rdata = WORD_W'(dev_sts);
      A_CMD:     cfg_rdata = WORD_W'(serr_en) << CMD_SERR;
      A_LEG_STS: cfg_rdata = (WORD_W'(leg_sta) << LS_STA) | (WORD_W'(leg_sse) << LS_SSE);
      default: begin
        for (int k = 0; k < HDR_DW; k++)
          if (cfg_addr == A_LOG0 + ADDR_W'(k)) cfg_rdata = hdr_log[k];
      end
    endcase
  end
endmodule

// File: rtl/aer_err_report.sv
module aer_err_report
  import aer_pkg::*;
#(
  parameter int          STS_W    = 32,
  parameter int          ID_W     = $clog2(STS_W),
  parameter int          HDR_DW   = 4,
  parameter int          UR_BIT   = 20,
  parameter int          CA_BIT   = 15,
  parameter logic [11:0] NEXT_RST = 12'h000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_valid,
  input  logic                     ev_uncorr,
  input  logic [ID_W-1:0]          ev_id,
  input  logic [HDR_DW*WORD_W-1:0] ev_hdr,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [WORD_W-1:0]        cfg_wdata,
  output logic [WORD_W-1:0]        cfg_rdata,
  output logic                     msg_valid,
  output logic [1:0]               msg_code
);
  logic [STS_W-1:0] unc_sts_w, unc_mask_w, unc_sev_w, cor_sts_w, cor_mask_w;
  logic [STS_W-1:0] unc_set, cor_set;
  logic [3:0]       dev_en_w, dev_set;
  logic             serr_en_w, sta_set, sse_set, capture, fire;
  msg_code_e        code;

  aer_err_eval #(.STS_W(STS_W), .ID_W(ID_W), .UR_BIT(UR_BIT), .CA_BIT(CA_BIT)) u_eval (
    .ev_valid(ev_valid), .ev_uncorr(ev_uncorr), .ev_id(ev_id),
    .unc_sts(unc_sts_w), .unc_mask(unc_mask_w), .unc_sev(unc_sev_w),
    .cor_mask(cor_mask_w), .dev_en(dev_en_w), .serr_en(serr_en_w),
    .unc_set(unc_set), .cor_set(cor_set), .dev_set(dev_set),
    .sta_set(sta_set), .sse_set(sse_set), .capture(capture),
    .fire(fire), .code(code)
  );

  aer_reg_bank #(.STS_W(STS_W), .ID_W(ID_W), .HDR_DW(HDR_DW), .NEXT_RST(NEXT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_id(ev_id), .ev_hdr(ev_hdr),
    .unc_set(unc_set), .cor_set(cor_set), .dev_set(dev_set),
    .sta_set(sta_set), .sse_set(sse_set), .capture(capture),
    .unc_sts(unc_sts_w), .unc_mask(unc_mask_w), .unc_sev(unc_sev_w),
    .cor_sts(cor_sts_w), .cor_mask(cor_mask_w), .dev_en(dev_en_w), .serr_en(serr_en_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_code  <= MSG_COR;
    end else begin
      msg_valid <= fire;
      msg_code  <= fire ? code : MSG_COR;
    end
  end
endmodule

// File: rtl/aer_err_report_chk.sv
module aer_err_report_chk #(
  parameter int STS_W  = 32,
  parameter int ID_W   = 5,
  parameter int UR_BIT = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_uncorr,
  input logic [ID_W-1:0]  ev_id,
  input logic             msg_valid,
  input logic [1:0]       msg_code,
  input logic [STS_W-1:0] unc_mask,
  input logic [STS_W-1:0] cor_sts,
  input logic [3:0]       dev_en
);
  a_r9_msg_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(ev_valid));

  a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_code != 2'd3));

  a_r2_cor_code_match: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((msg_code == 2'd0) == $past(!ev_uncorr)));

  a_r1_cor_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_uncorr) |=> cor_sts[$past(ev_id)]);

  a_r5_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_uncorr && unc_mask[ev_id]) |=> !msg_valid);

  a_r7_ur_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_uncorr && ev_id == ID_W'(UR_BIT) && !dev_en[3]) |=> !msg_valid);
endmodule

bind aer_err_report aer_err_report_chk #(.STS_W(STS_W), .ID_W(ID_W), .UR_BIT(UR_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr), .ev_id(ev_id),
  .msg_valid(msg_valid), .msg_code(msg_code), .unc_mask(unc_mask_w),
  .cor_sts(cor_sts_w), .dev_en(dev_en_w)
);

// File: tb/aer_err_report_bench.sv
module aer_err_report_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ev_valid = 1'b0, ev_uncorr = 1'b0;
  logic [4:0]   ev_id = '0;
  logic [127:0] ev_hdr = '0;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0, cfg_rdata;
  logic         msg_valid;
  logic [1:0]   msg_code;
  int n_run = 0, n_fail = 0;
  logic         got_v;
  logic [1:0]   got_c;

  always #5 clk = ~clk;

  aer_err_report u_aer_err_report (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr),
    .ev_id(ev_id), .ev_hdr(ev_hdr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msg_valid(msg_valid), .msg_code(msg_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic fire(input logic unc, input logic [4:0] id, input logic [127:0] h);
    @(negedge clk); ev_valid = 1'b1; ev_uncorr = unc; ev_id = id; ev_hdr = h;
    @(posedge clk); #1 got_v = msg_valid; got_c = msg_code;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(4'd0, d);  check("R10 cap header", d, 32'h0001_0001);
    rd(4'd6, d);  check("R10 ctrl reset", d, 32'h0000_01E0);
    rd(4'd1, d);  check("R10 unc status reset", d, 0);
    check("R9 no message at reset", {31'b0, msg_valid}, 0);
    wr(4'd0, 32'hABC0_0000);
    rd(4'd0, d);  check("R10 next pointer write", d, 32'hABC1_0001);
    wr(4'd6, 32'h0000_001F);
    rd(4'd6, d);  check("R11 pointer ignores write", d, 32'h0000_0000);
  endtask

  task automatic t_correctable();
    logic [31:0] d;
    do_reset();
    wr(4'd11, 32'h1);
    fire(1'b0, 5'd6, '0);
    check("R2 cor message", {30'b0, got_v, got_c}, 32'h4);
    @(posedge clk); #1 check("R9 single pulse", {31'b0, msg_valid}, 0);
    rd(4'd4, d);  check("R1 cor status", d, 32'h40);
    rd(4'd12, d); check("R1 dev status cor", d, 32'h1);
    wr(4'd5, 32'h40);
    fire(1'b0, 5'd6, '0);
    check("R2 masked cor silent", {31'b0, got_v}, 0);
    wr(4'd11, 32'h0);
    fire(1'b0, 5'd7, '0);
    check("R2 cor disabled silent", {31'b0, got_v}, 0);
  endtask

  task automatic t_first_error();
    logic [31:0] d;
    do_reset();
    wr(4'd11, 32'h2);
    fire(1'b1, 5'd12, 128'h44444444_33333333_22222222_11111111);
    check("R8 nonfatal message", {30'b0, got_v, got_c}, 32'h5);
    rd(4'd6, d);  check("R6 first pointer", d, 32'h1EC);
    rd(4'd7, d);  check("R6 log0", d, 32'h11111111);
    rd(4'd10, d); check("R6 log3", d, 32'h44444444);
    rd(4'd14, d); check("R8 signaled system error", d, 32'h4000);
    rd(4'd12, d); check("R3 dev status nonfatal", d, 32'h2);
    fire(1'b1, 5'd18, {4{32'hDEADBEEF}});
    rd(4'd6, d);  check("R6 pointer kept", d, 32'h1EC);
    rd(4'd8, d);  check("R6 log1 kept", d, 32'h22222222);
    wr(4'd7, 32'h0);
    rd(4'd7, d);  check("R11 log read-only", d, 32'h11111111);
    rd(4'd1, d);  check("R3 unc status", d, 32'h0004_1000);
  endtask

  task automatic t_fatal_serr();
    logic [31:0] d;
    do_reset();
    wr(4'd3, 32'h0000_2000);
    wr(4'd13, 32'h100);
    fire(1'b1, 5'd13, '0);
    check("R8 fatal via SERR", {30'b0, got_v, got_c}, 32'h6);
    rd(4'd12, d); check("R3 dev status fatal", d, 32'h4);
    wr(4'd13, 32'h0);
    fire(1'b1, 5'd14, '0);
    check("R8 no enable silent", {31'b0, got_v}, 0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    do_reset();
    wr(4'd11, 32'hF); wr(4'd13, 32'h100); wr(4'd2, 32'h10);
    fire(1'b1, 5'd4, {4{32'h55AA55AA}});
    check("R5 masked silent", {31'b0, got_v}, 0);
    rd(4'd1, d);  check("R3 masked status set", d, 32'h10);
    rd(4'd6, d);  check("R5 no pointer", d, 32'h1E0);
    rd(4'd7, d);  check("R5 no log", d, 32'h0);
    rd(4'd14, d); check("R5 no SSE", d, 32'h0);
    rd(4'd12, d); check("R3 masked dev status", d, 32'h2);
  endtask

  task automatic t_ur_ca();
    logic [31:0] d;
    do_reset();
    wr(4'd13, 32'h100); wr(4'd11, 32'h7);
    fire(1'b1, 5'd20, '0);
    check("R7 UR disabled silent", {31'b0, got_v}, 0);
    rd(4'd12, d); check("R4 UR dev status", d, 32'hA);
    rd(4'd14, d); check("R7 UR no SSE", d, 32'h0);
    wr(4'd11, 32'h8); wr(4'd3, 32'h0010_0000);
    fire(1'b1, 5'd20, '0);
    check("R7 UR fatal message", {30'b0, got_v, got_c}, 32'h6);
    wr(4'd2, 32'h8000);
    fire(1'b1, 5'd15, '0);
    rd(4'd14, d); check("R4 CA target abort when masked", d, 32'h0800);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    do_reset();
    wr(4'd11, 32'h1);
    fire(1'b0, 5'd3, '0);
    fire(1'b0, 5'd5, '0);
    @(negedge clk);
    ev_valid = 1'b1; ev_uncorr = 1'b0; ev_id = 5'd3;
    cfg_we = 1'b1; cfg_addr = 4'd4; cfg_wdata = 32'h28;
    @(negedge clk); ev_valid = 1'b0; cfg_we = 1'b0;
    rd(4'd4, d); check("R11 set wins over clear", d, 32'h8);
    @(negedge clk);
    ev_valid = 1'b1; ev_id = 5'd9;
    cfg_we = 1'b1; cfg_addr = 4'd5; cfg_wdata = 32'h200;
    @(posedge clk); #1 check("R12 old mask used", {31'b0, msg_valid}, 1);
    @(negedge clk); cfg_we = 1'b0; ev_valid = 1'b0;
    fire(1'b0, 5'd9, '0);
    check("R12 new mask used", {31'b0, got_v}, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_correctable();
    t_first_error();
    t_fatal_serr();
    t_masked();
    t_ur_ca();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule